// File: doc/BRIEF.md
# Filter Compute Microsequencer

This block is a small program-driven controller that decides when a shared filter engine begins each computation. A host loads a 32-step program and a handful of control registers through a single write port, then sets a run bit. From then on the sequencer fetches one instruction per cycle from its program store, decodes it as a WAIT, a FIR or a conditional JUMP, and acts on it. Conditions test a wait counter against a threshold, a loop counter against zero, resampler carry inputs, a sync input or a host flag, or nothing at all.

FIR instructions carry strobes for the filter engine. They can start a computation with a filter type and steps-per-FIR field, request a resampler increment, and enable a quarter-rate rotator whose phase steps through 1, j, -1, -j. The same instructions can also lower the wait counter by one of two host-set amounts, load the loop counter from an immediate that shares the filter-parameter bits, or decrement the loop counter. A FIR that requests a start stalls until the engine is idle and no start is already in flight.

Top module: `fcs_microseq`

## Requirements
- R1: After a synchronous active-low reset, pc, wait_cnt and loop_cnt are 0, and fe_start, rot_en and rs_incr are 0.
- R2: Instruction bit 8 set selects JUMP. Otherwise bit 7 selects FIR (1) or WAIT (0).
- R3: A JUMP whose condition (bits 2:0) holds loads pc with bits 7:3. Otherwise pc advances by one, and the advance from step 31 wraps to step 0.
- R4: A WAIT holds pc while its condition (bits 2:0) is false and advances pc by one in the cycle it is true. Bits 6:3 are ignored.
- R5: Condition 000 is true when wait_cnt is below the threshold, and 001 is true when wait_cnt is at or above it.
- R6: Condition 010 is true when loop_cnt is nonzero and 011 when it is zero. 100 follows rs_carry_tab and 101 follows rs_carry. 110 follows sync_in if sync is enabled and the host flag otherwise. 111 is always true.
- R7: A FIR with bit 6 set waits while fe_idle is low or fe_start is high. It then advances pc and raises fe_start for exactly one cycle in the next cycle, with fe_type = bits 14:9 and fe_steps = bits 17:15.
- R8: A FIR with bit 3 set lowers wait_cnt, once as it executes, by the second decrement amount when bit 4 is 1 and by the first amount otherwise. It saturates at 0.
- R9: A FIR with bit 2 set loads loop_cnt from bits 20:9. Bit 1 decrements loop_cnt, saturating at 0. A load wins over a decrement in the same instruction.
- R10: A starting FIR with bit 0 set raises rot_en with fe_start. rot_phase gives the rotator phase 0, 1, 2, 3, advancing by one after each rotated start.
- R11: Bit 5 of a starting FIR requests a resampler increment. With control bit 3 clear, rs_incr pulses with fe_start. With it set, rs_incr pulses the cycle after each fe_out_valid until the next start.
- R12: Host addresses 0-31 write program steps. 32 writes wait_cnt, 33 the threshold, 34 and 35 the two decrement amounts, and 36 the control bits: 0 run, 1 sync enable, 2 host flag, 3 resampler-on-output. A host write to wait_cnt overrides a same-cycle decrement. With run clear, pc is forced to 0 and no start issues.
- R13: A FIR with bit 6 clear issues no fe_start and advances pc by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host write address |
| host_wdata | input | 21 | Host write data |
| fe_idle | input | 1 | Filter engine is idle |
| fe_out_valid | input | 1 | Filter engine produced an output |
| rs_carry | input | 1 | Resampler carry |
| rs_carry_tab | input | 1 | Resampler carry tab |
| sync_in | input | 1 | External sync event |
| fe_start | output | 1 | One-cycle filter start strobe |
| fe_type | output | 6 | Filter type for the started filter |
| fe_steps | output | 3 | Steps per FIR minus one |
| rot_en | output | 1 | Rotator enabled for the started filter |
| rot_phase | output | 2 | Rotator phase for the started filter |
| rs_incr | output | 1 | Resampler increment strobe |
| pc | output | 5 | Current program step |
| wait_cnt | output | 16 | Wait counter |
| loop_cnt | output | 12 | Loop counter |

## Verification
The host load of wait_cnt and a FIR-driven wait decrement can land on the same clock edge. This is the collision the bench provokes on purpose. It starts a program whose first step lowers wait_cnt and, on the very edge where that step executes, issues a host write of a new count. It then judges that wait_cnt holds exactly the written value and not that value minus the decrement, and that pc still advanced. A second overlap, a loop load and loop decrement in one instruction, is judged by reading loop_cnt right after that step.

// File: rtl/fcs_pkg.sv
// Shared definitions for the filter compute microsequencer.
// Assumes a fixed 21-bit instruction word; field positions are decoded by
// the sequencer and by the filter engine, so they are kept here.
package fcs_pkg;
    localparam int INSTR_W   = 21;
    localparam int LOOP_IMM_W = 12;   // bits 20:9
    localparam int TYPE_W    = 6;     // bits 14:9
    localparam int STEPS_W   = 3;     // bits 17:15
    localparam int CC_W      = 3;

    typedef enum logic [1:0] {
        KIND_WAIT = 2'd0,
        KIND_FIR  = 2'd1,
        KIND_JUMP = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        CC_WC_BELOW = 3'd0,
        CC_WC_ATLEAST = 3'd1,
        CC_LOOP_NZ  = 3'd2,
        CC_LOOP_Z   = 3'd3,
        CC_RS_TAB   = 3'd4,
        CC_RS_CARRY = 3'd5,
        CC_EVENT    = 3'd6,
        CC_ALWAYS   = 3'd7
    } cond_e;

    // register indices in the upper half of the host address space
    localparam logic [4:0] REG_WAIT  = 5'd0;
    localparam logic [4:0] REG_THR   = 5'd1;
    localparam logic [4:0] REG_DEC0  = 5'd2;
    localparam logic [4:0] REG_DEC1  = 5'd3;
    localparam logic [4:0] REG_CTRL  = 5'd4;
endpackage

// File: rtl/fcs_prog_mem.sv
// Program store: DEPTH words of W bits, one host write port and one
// combinational read port addressed by the program counter.
// Assumes writes and reads may hit the same word; the read sees the old word.
module fcs_prog_mem #(
    parameter int DEPTH = 32,
    parameter int W     = 21,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] words [DEPTH];

    // Store host writes; reset clears every step to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    // Present the step selected by the program counter.
    always_comb rd_data = words[rd_addr];
endmodule

// File: rtl/fcs_counters.sv
// Wait counter and loop counter.
// The wait counter is host-loadable and decremented by a chosen amount,
// saturating at zero; a host load wins. The loop counter is loaded from an
// instruction immediate or decremented, saturating at zero; a load wins.
module fcs_counters #(
    parameter int WCNT_W = 16,
    parameter int LOOP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wset_en,
    input  logic [WCNT_W-1:0] wset_val,
    input  logic              wdec_en,
    input  logic [WCNT_W-1:0] wdec_amt,
    input  logic              lload_en,
    input  logic [LOOP_W-1:0] lload_val,
    input  logic              ldec_en,
    output logic [WCNT_W-1:0] wcnt,
    output logic [LOOP_W-1:0] lcnt
);
    // Update the wait counter: host load first, then saturating decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)       wcnt <= '0;
        else if (wset_en) wcnt <= wset_val;
        else if (wdec_en) wcnt <= (wcnt > wdec_amt) ? wcnt - wdec_amt : '0;
    end

    // Update the loop counter: immediate load first, then saturating decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                      lcnt <= '0;
        else if (lload_en)               lcnt <= lload_val;
        else if (ldec_en && lcnt != '0)  lcnt <= lcnt - LOOP_W'(1);
    end

    // R8: a decrement larger than the count leaves zero
    assert_wait_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wdec_en && !wset_en && wcnt <= wdec_amt) |=> wcnt == '0);

    // R12: host load overrides a same-cycle decrement
    assert_host_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wset_en && wdec_en) |=> wcnt == $past(wset_val));

    // R9: immediate load takes priority over decrement
    assert_loop_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lload_en |=> lcnt == $past(lload_val));
endmodule

// File: rtl/fcs_cond.sv
// Condition evaluator: picks one of eight tests by condition code.
// Assumes all inputs are synchronous to the sequencer clock.
module fcs_cond
    import fcs_pkg::*;
#(
    parameter int WCNT_W = 16,
    parameter int LOOP_W = 12
) (
    input  logic [CC_W-1:0]   cc,
    input  logic [WCNT_W-1:0] wcnt,
    input  logic [WCNT_W-1:0] thr,
    input  logic [LOOP_W-1:0] lcnt,
    input  logic              rs_tab,
    input  logic              rs_carry,
    input  logic              sync_in,
    input  logic              sync_en,
    input  logic              host_flag,
    output logic              hit
);
    // Select the test named by the condition code.
    always_comb begin
        unique case (cond_e'(cc))
            CC_WC_BELOW:   hit = (wcnt < thr);
            CC_WC_ATLEAST: hit = (wcnt >= thr);
            CC_LOOP_NZ:    hit = (lcnt != '0);
            CC_LOOP_Z:     hit = (lcnt == '0);
            CC_RS_TAB:     hit = rs_tab;
            CC_RS_CARRY:   hit = rs_carry;
            CC_EVENT:      hit = sync_en ? sync_in : host_flag;
            default:       hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/fcs_microseq.sv
// Filter compute microsequencer top.
// Fetches one instruction per cycle, decodes WAIT/FIR/JUMP, drives the
// counters and the filter-engine strobes. Assumes the program depth is a
// power of two so the program counter wraps naturally; a started filter is
// treated as busy for the cycle its fe_start is high.
module fcs_microseq
    import fcs_pkg::*;
#(
    parameter int PROG_DEPTH = 32,
    parameter int WCNT_W     = 16,
    localparam int PC_W      = $clog2(PROG_DEPTH),
    localparam int HADDR_W   = PC_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [INSTR_W-1:0] host_wdata,
    input  logic               fe_idle,
    input  logic               fe_out_valid,
    input  logic               rs_carry,
    input  logic               rs_carry_tab,
    input  logic               sync_in,
    output logic               fe_start,
    output logic [TYPE_W-1:0]  fe_type,
    output logic [STEPS_W-1:0] fe_steps,
    output logic               rot_en,
    output logic [1:0]         rot_phase,
    output logic               rs_incr,
    output logic [PC_W-1:0]    pc,
    output logic [WCNT_W-1:0]  wait_cnt,
    output logic [LOOP_IMM_W-1:0] loop_cnt
);
    logic [PC_W-1:0]    pc_q;
    logic [INSTR_W-1:0] instr;
    logic [WCNT_W-1:0]  thr_q, dec0_q, dec1_q;
    logic               run_q, sync_en_q, host_flag_q, rs_on_out_q;
    logic               mem_we, reg_we;
    logic [PC_W-1:0]    reg_idx;
    kind_e              kind;
    logic               hit, want_start, engine_ready, fir_go, start_now;
    logic [PC_W-1:0]    pc_next;
    logic [1:0]         phase_q;
    logic               rs_armed_q;

    // Split host writes between program store and registers.
    always_comb begin
        mem_we  = host_we && !host_addr[PC_W];
        reg_we  = host_we &&  host_addr[PC_W];
        reg_idx = host_addr[PC_W-1:0];
    end

    // Hold the threshold, decrement amounts and control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0; dec0_q <= '0; dec1_q <= '0;
            run_q <= 1'b0; sync_en_q <= 1'b0; host_flag_q <= 1'b0; rs_on_out_q <= 1'b0;
        end else if (reg_we) begin
            if (reg_idx == PC_W'(REG_THR))  thr_q  <= host_wdata[WCNT_W-1:0];
            if (reg_idx == PC_W'(REG_DEC0)) dec0_q <= host_wdata[WCNT_W-1:0];
            if (reg_idx == PC_W'(REG_DEC1)) dec1_q <= host_wdata[WCNT_W-1:0];
            if (reg_idx == PC_W'(REG_CTRL)) begin
                run_q       <= host_wdata[0];
                sync_en_q   <= host_wdata[1];
                host_flag_q <= host_wdata[2];
                rs_on_out_q <= host_wdata[3];
            end
        end
    end

    fcs_prog_mem #(.DEPTH(PROG_DEPTH), .W(INSTR_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(mem_we), .wr_addr(host_addr[PC_W-1:0]), .wr_data(host_wdata),
        .rd_addr(pc_q), .rd_data(instr)
    );

    // Decode the instruction kind from bits 8:7.
    always_comb begin
        if (instr[8])      kind = KIND_JUMP;
        else if (instr[7]) kind = KIND_FIR;
        else               kind = KIND_WAIT;
    end

    fcs_cond #(.WCNT_W(WCNT_W), .LOOP_W(LOOP_IMM_W)) u_cond (
        .cc(instr[2:0]), .wcnt(wait_cnt), .thr(thr_q), .lcnt(loop_cnt),
        .rs_tab(rs_carry_tab), .rs_carry(rs_carry), .sync_in(sync_in),
        .sync_en(sync_en_q), .host_flag(host_flag_q), .hit(hit)
    );

    // Decide whether a FIR executes this cycle and whether it starts a filter.
    always_comb begin
        want_start   = (kind == KIND_FIR) && instr[6];
        engine_ready = fe_idle && !fe_start;
        fir_go       = run_q && (kind == KIND_FIR) && (!instr[6] || engine_ready);
        start_now    = fir_go && instr[6];
    end

    // Choose the next program step.
    always_comb begin
        pc_next = pc_q;
        if (!run_q) begin
            pc_next = '0;
        end else begin
            unique case (kind)
                KIND_JUMP: pc_next = hit ? instr[7:3] : pc_q + PC_W'(1);
                KIND_WAIT: pc_next = hit ? pc_q + PC_W'(1) : pc_q;
                default:   pc_next = fir_go ? pc_q + PC_W'(1) : pc_q;
            endcase
        end
    end

    // Register the program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    fcs_counters #(.WCNT_W(WCNT_W), .LOOP_W(LOOP_IMM_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .wset_en(reg_we && reg_idx == PC_W'(REG_WAIT)),
        .wset_val(host_wdata[WCNT_W-1:0]),
        .wdec_en(fir_go && instr[3]),
        .wdec_amt(instr[4] ? dec1_q : dec0_q),
        .lload_en(fir_go && instr[2]),
        .lload_val(instr[20:9]),
        .ldec_en(fir_go && instr[1]),
        .wcnt(wait_cnt), .lcnt(loop_cnt)
    );

    // Drive the start strobe and its parameter fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_start <= 1'b0; fe_type <= '0; fe_steps <= '0;
        end else begin
            fe_start <= start_now;
            if (start_now) begin
                fe_type  <= instr[14:9];
                fe_steps <= instr[17:15];
            end
        end
    end

    // Drive the rotator enable and step its phase once per rotated start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_en <= 1'b0; rot_phase <= '0; phase_q <= '0;
        end else begin
            rot_en <= start_now && instr[0];
            if (start_now && instr[0]) begin
                rot_phase <= phase_q;
                phase_q   <= phase_q + 2'd1;
            end
        end
    end

    // Drive the resampler increment on start or on each filter output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_incr <= 1'b0; rs_armed_q <= 1'b0;
        end else begin
            if (start_now) rs_armed_q <= instr[5];
            rs_incr <= rs_on_out_q ? (rs_armed_q && fe_out_valid)
                                   : (start_now && instr[5]);
        end
    end

    always_comb pc = pc_q;

    // R7: the start strobe never lasts two cycles
    assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fe_start |=> !fe_start);

    // R7: a start follows a cycle in which the engine was idle
    assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fe_start |-> $past(fe_idle));

    // R4: a WAIT with a false condition holds the step
    assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && kind == KIND_WAIT && !hit) |=> $stable(pc_q));

    // R3: a taken JUMP lands on its destination
    assert_jump_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && kind == KIND_JUMP && hit) |=> pc_q == $past(instr[7:3]));

    // R12: with run clear the sequencer parks at step 0 and starts nothing
    assert_parked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> (pc_q == '0 && !fe_start));
endmodule

// File: tb/test_fcs_microseq.sv
`timescale 1ns/1ps
module test_fcs_microseq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [20:0] host_wdata = '0;
    logic        fe_idle = 1'b1, fe_out_valid = 1'b0;
    logic        rs_carry = 1'b0, rs_carry_tab = 1'b0, sync_in = 1'b0;
    logic        fe_start, rot_en, rs_incr;
    logic [5:0]  fe_type;
    logic [2:0]  fe_steps;
    logic [1:0]  rot_phase;
    logic [4:0]  pc;
    logic [15:0] wait_cnt;
    logic [11:0] loop_cnt;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fcs_microseq i_fcs_microseq (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .fe_idle(fe_idle), .fe_out_valid(fe_out_valid),
        .rs_carry(rs_carry), .rs_carry_tab(rs_carry_tab), .sync_in(sync_in),
        .fe_start(fe_start), .fe_type(fe_type), .fe_steps(fe_steps),
        .rot_en(rot_en), .rot_phase(rot_phase), .rs_incr(rs_incr), .pc(pc),
        .wait_cnt(wait_cnt), .loop_cnt(loop_cnt)
    );

    // vector: [52:50] cc, [49:34] wait, [33:18] thr, [17:6] loop,
    // [5] tab, [4] carry, [3] sync, [2] sync_en, [1] host flag, [0] taken
    localparam int NV = 15;
    localparam logic [52:0] VECS [NV] = '{
        {3'd0, 16'd5, 16'd9, 12'd0, 5'b00000, 1'b1},
        {3'd0, 16'd9, 16'd9, 12'd0, 5'b00000, 1'b0},
        {3'd1, 16'd9, 16'd9, 12'd0, 5'b00000, 1'b1},
        {3'd1, 16'd3, 16'd9, 12'd0, 5'b00000, 1'b0},
        {3'd2, 16'd0, 16'd0, 12'd4, 5'b00000, 1'b1},
        {3'd2, 16'd0, 16'd0, 12'd0, 5'b00000, 1'b0},
        {3'd3, 16'd0, 16'd0, 12'd0, 5'b00000, 1'b1},
        {3'd4, 16'd0, 16'd0, 12'd0, 5'b10000, 1'b1},
        {3'd4, 16'd0, 16'd0, 12'd0, 5'b01000, 1'b0},
        {3'd5, 16'd0, 16'd0, 12'd0, 5'b01000, 1'b1},
        {3'd6, 16'd0, 16'd0, 12'd0, 5'b00110, 1'b1},
        {3'd6, 16'd0, 16'd0, 12'd0, 5'b00011, 1'b0},
        {3'd6, 16'd0, 16'd0, 12'd0, 5'b00100, 1'b0},
        {3'd6, 16'd0, 16'd0, 12'd0, 5'b00001, 1'b1},
        {3'd7, 16'd0, 16'd0, 12'd0, 5'b00000, 1'b1}
    };

    function automatic logic [20:0] fir(input logic [11:0] p, input logic [6:0] f);
        return {p, 2'b01, f};
    endfunction
    function automatic logic [20:0] jmp(input logic [4:0] d, input logic [2:0] c);
        return {12'd0, 1'b1, d, c};
    endfunction
    function automatic logic [20:0] wt(input logic [2:0] c);
        return {12'd0, 2'b00, 4'b1111, c};   // bits 6:3 set to show they are ignored
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic hwr(input logic [5:0] a, input logic [20:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        tick();
        host_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; fe_idle = 1'b1; fe_out_valid = 1'b0;
        rs_carry = 1'b0; rs_carry_tab = 1'b0; sync_in = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    localparam logic [5:0] A_WAIT = 6'd32, A_THR = 6'd33, A_DEC0 = 6'd34,
                           A_DEC1 = 6'd35, A_CTRL = 6'd36;

    initial begin
        #900000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 pc", pc, 0);
        chk("R1 wait", wait_cnt, 0);
        chk("R1 loop", loop_cnt, 0);
        chk("R1 start", fe_start, 0);
        chk("R1 rot/rs", {rot_en, rs_incr}, 0);

        // Condition table: R2 R3 R5 R6
        for (int v = 0; v < NV; v++) begin
            logic [52:0] e;
            e = VECS[v];
            do_reset();
            hwr(A_WAIT, 21'(e[49:34]));
            hwr(A_THR, 21'(e[33:18]));
            hwr(6'd0, fir(e[17:6], 7'b0000100));
            hwr(6'd1, jmp(5'd10, e[52:50]));
            rs_carry_tab = e[5]; rs_carry = e[4]; sync_in = e[3];
            hwr(A_CTRL, {17'd0, 1'b0, e[1], e[2], 1'b1});
            tick(2);
            chk($sformatf("R5/R6 cc%0d vec%0d", e[52:50], v), pc, e[0] ? 10 : 2);
        end

        // R7 R8 R10 R11: stall, single start, fields, rotator, increment on start
        do_reset();
        hwr(A_WAIT, 21'd5);
        hwr(A_DEC0, 21'd1);
        hwr(6'd0, fir({3'd0, 3'd1, 6'd5}, 7'b1101001));
        hwr(6'd1, fir({3'd0, 3'd0, 6'd2}, 7'b1000001));
        hwr(6'd2, jmp(5'd2, 3'd7));
        fe_idle = 1'b0;
        hwr(A_CTRL, 21'd1);
        tick(3);
        chk("R7 stall pc", pc, 0);
        chk("R7 stall start", fe_start, 0);
        chk("R8 no decrement while stalled", wait_cnt, 5);
        fe_idle = 1'b1;
        tick();
        chk("R7 start", fe_start, 1);
        chk("R7 type", fe_type, 5);
        chk("R7 steps", fe_steps, 1);
        chk("R10 rot_en", rot_en, 1);
        chk("R10 phase0", rot_phase, 0);
        chk("R11 incr on start", rs_incr, 1);
        chk("R8 dec once", wait_cnt, 4);
        chk("R7 pc advance", pc, 1);
        tick();
        chk("R7 single pulse", fe_start, 0);
        chk("R7 pending stalls", pc, 1);
        tick();
        chk("R7 second start", fe_start, 1);
        chk("R7 type2", fe_type, 2);
        chk("R10 phase1", rot_phase, 1);
        chk("R11 no incr", rs_incr, 0);

        // R11: increment on filter output
        do_reset();
        hwr(6'd0, fir({3'd0, 3'd0, 6'd1}, 7'b1100000));
        hwr(6'd1, jmp(5'd1, 3'd7));
        hwr(A_CTRL, 21'd9);
        tick();
        chk("R11 start", fe_start, 1);
        chk("R11 no incr at start", rs_incr, 0);
        fe_out_valid = 1'b1;
        tick();
        fe_out_valid = 1'b0;
        chk("R11 incr on output", rs_incr, 1);
        tick();
        chk("R11 incr drops", rs_incr, 0);

        // R8 R13: dual-rate decrement with saturation, no-op FIRs
        do_reset();
        hwr(A_WAIT, 21'd10);
        hwr(A_DEC0, 21'd3);
        hwr(A_DEC1, 21'd4);
        hwr(6'd0, fir(12'd0, 7'b0001000));
        hwr(6'd1, fir(12'd0, 7'b0011000));
        hwr(6'd2, fir(12'd0, 7'b0011000));
        hwr(6'd3, jmp(5'd3, 3'd7));
        hwr(A_CTRL, 21'd1);
        tick();
        chk("R8 dec0", wait_cnt, 7);
        chk("R13 pc", pc, 1);
        tick();
        chk("R8 dec1", wait_cnt, 3);
        tick();
        chk("R8 floor", wait_cnt, 0);
        chk("R13 no start", fe_start, 0);
        chk("R13 pc3", pc, 3);

        // R9: loop load, decrement, load priority, counted loop
        do_reset();
        hwr(6'd0, fir(12'd3, 7'b0000100));
        hwr(6'd1, fir(12'd0, 7'b0000010));
        hwr(6'd2, fir(12'd7, 7'b0000110));
        hwr(6'd3, fir(12'd0, 7'b0000010));
        hwr(6'd4, jmp(5'd3, 3'd2));
        hwr(6'd5, jmp(5'd5, 3'd7));
        hwr(A_CTRL, 21'd1);
        tick();
        chk("R9 load", loop_cnt, 3);
        tick();
        chk("R9 dec", loop_cnt, 2);
        tick();
        chk("R9 load wins", loop_cnt, 7);
        tick(30);
        chk("R9 loop done pc", pc, 5);
        chk("R9 loop zero", loop_cnt, 0);

        // R4: WAIT on host flag
        do_reset();
        hwr(6'd0, wt(3'd6));
        hwr(6'd1, jmp(5'd1, 3'd7));
        hwr(A_CTRL, 21'd1);
        tick(4);
        chk("R4 hold", pc, 0);
        hwr(A_CTRL, 21'd5);
        tick();
        chk("R4 release", pc, 1);

        // R3: wrap from 31 to 0
        do_reset();
        hwr(6'd0, jmp(5'd31, 3'd7));
        hwr(6'd31, fir(12'd0, 7'd0));
        hwr(A_CTRL, 21'd1);
        tick();
        chk("R3 jump 31", pc, 31);
        tick();
        chk("R3 wrap", pc, 0);

        // R12: host load collides with decrement
        do_reset();
        hwr(A_WAIT, 21'd8);
        hwr(A_DEC0, 21'd1);
        hwr(6'd0, fir(12'd0, 7'b0001000));
        hwr(6'd1, jmp(5'd1, 3'd7));
        hwr(A_CTRL, 21'd1);
        hwr(A_WAIT, 21'd20);
        chk("R12 host wins", wait_cnt, 20);
        chk("R12 pc advanced", pc, 1);

        // R12: run clear keeps pc at 0 and issues nothing
        do_reset();
        hwr(6'd0, fir(12'd1, 7'b1000000));
        tick(3);
        chk("R12 parked pc", pc, 0);
        chk("R12 parked start", fe_start, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule